// File: doc/BRIEF.md
# Tiled Memory Composition Wrapper

The wrapper presents one logical single-port memory of a chosen width and depth while storing the data in a grid of small fixed-size tiles. The data word is cut into contiguous slices, and each slice goes to one tile column. The tile columns are placed side by side. The last column may be only partly used. Its unused upper bits are padded with zero on writes and dropped on reads. To cover the depth, the tiles are arranged in banks. The address bits above the tile index choose one bank, and only that bank sees active control pins. The lower address bits go to every tile in parallel.

Each tile control pin (chip enable, write enable, read enable) can be set, per pin, to be active-high or active-low. The wrapper inverts its internal active-high strobes wherever the tile expects the low sense. Every tile also has a small configuration input that is not part of the memory port. The wrapper ties this input to a fixed constant. A tile accepts writes only when that input carries its expected key.

Reads use a held-address scheme. An enabled read captures the low address inside the tiles and the bank number inside the wrapper. The output then shows the word at that held location until the next enabled read. This is the same behaviour as a memory with a registered read address and combinational data. The tile model included here is a behavioural stand-in that can be mapped to block RAM.

Top module: `tiled_mem`

## Requirements
- R1: A write stores data only in the lanes selected by `mem_wmask`. Lane k covers data bits (k+1)*GRAN-1 down to k*GRAN. Lanes whose mask bit is 0 keep their old contents.
- R2: A read is issued when `mem_en` and `mem_re` are both 1 at a rising edge. From just after that edge, `mem_rdata` shows the word stored at the issued address.
- R3: While no read is issued, `mem_rdata` keeps showing the word at the last held address, whatever `mem_addr` does. When nothing is written either, `mem_rdata` does not change.
- R4: The address bits from bit log2(TILE_DEPTH) upward select exactly one bank. A write to one bank leaves the same low address in every other bank unchanged.
- R5: All DATA_W bits are stored independently across the tile columns. This includes a last column that is only partly used.
- R6: A write takes place only when `mem_en` and `mem_we` are both 1. When `mem_en` is 0, `mem_we` has no effect and no bank strobe is active.
- R7: After a synchronous reset, the held read location is address 0, so `mem_rdata` reads as 0 (the storage starts cleared).
- R8: The function is the same whichever pin sense (active-high or active-low) is chosen for each tile control pin.
- R9: The tile configuration input is tied to a constant, and that constant equals the key the tiles need. Writes therefore succeed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_en | input | 1 | Access enable |
| mem_we | input | 1 | Write strobe (qualified by mem_en) |
| mem_re | input | 1 | Read strobe (qualified by mem_en) |
| mem_addr | input | ADDR_W | Word address |
| mem_wdata | input | DATA_W | Write data |
| mem_wmask | input | DATA_W/GRAN | Per-lane write mask |
| mem_rdata | output | DATA_W | Word at the held read location |

## Verification
Two copies of the wrapper are driven side by side: one with all-high pin senses and one with active-low chip and write enables. Any difference between them points to the polarity adaptation. Directed writes to the same low address in different banks separate bank decoding faults from slicing faults. Single-lane masks, including the lane in the partial last column, show whether lane gating and column placement are correct. Idle cycles with a moving address show whether the held read location is really held. A long random run of masked writes, reads and ungated strobes across all bank boundaries is compared against a flat reference array.

// File: rtl/tiled_mem_pkg.sv
package tiled_mem_pkg;

  typedef enum logic {
    PIN_HIGH = 1'b0,
    PIN_LOW  = 1'b1
  } pin_pol_e;

  function automatic int cdiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

endpackage

// File: rtl/tm_pin_drv.sv
module tm_pin_drv
  import tiled_mem_pkg::*;
#(
  parameter pin_pol_e POL = PIN_HIGH
) (
  input  logic act,
  output logic pin
);
  generate
    if (POL == PIN_LOW) begin : g_low
      assign pin = ~act;
    end else begin : g_high
      assign pin = act;
    end
  endgenerate
endmodule

// File: rtl/tm_bank_dec.sv
module tm_bank_dec #(
  parameter int NBANK  = 4,
  parameter int BSEL_W = 2
) (
  input  logic              en,
  input  logic              we,
  input  logic              re,
  input  logic [BSEL_W-1:0] bsel,
  output logic [NBANK-1:0]  bank_ce,
  output logic [NBANK-1:0]  bank_we,
  output logic [NBANK-1:0]  bank_re
);
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hit;
    assign hit        = (bsel == BSEL_W'(b));
    assign bank_ce[b] = en & hit;
    assign bank_we[b] = bank_ce[b] & we;
    assign bank_re[b] = bank_ce[b] & re;
  end
endmodule

// File: rtl/tm_tile.sv
module tm_tile
  import tiled_mem_pkg::*;
#(
  parameter int          TW      = 8,
  parameter int          TD      = 16,
  parameter int          GRAN    = 4,
  parameter pin_pol_e    CE_POL  = PIN_HIGH,
  parameter pin_pol_e    WE_POL  = PIN_HIGH,
  parameter pin_pol_e    RE_POL  = PIN_HIGH,
  parameter int          CFG_W   = 4,
  parameter logic [CFG_W-1:0] CFG_KEY = 4'hA,
  localparam int         AW      = $clog2(TD),
  localparam int         NL      = TW / GRAN
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce_pin,
  input  logic             we_pin,
  input  logic             re_pin,
  input  logic [AW-1:0]    addr,
  input  logic [TW-1:0]    wdata,
  input  logic [NL-1:0]    wmask,
  input  logic [CFG_W-1:0] cfg,
  output logic [TW-1:0]    rdata
);
  logic          ce, we, re, wr, rd;
  logic [AW-1:0] raddr_q;
  logic [TW-1:0] store [TD];

  assign ce = (CE_POL == PIN_LOW) ? ~ce_pin : ce_pin;
  assign we = (WE_POL == PIN_LOW) ? ~we_pin : we_pin;
  assign re = (RE_POL == PIN_LOW) ? ~re_pin : re_pin;
  assign wr = ce & we & (cfg == CFG_KEY);
  assign rd = ce & re;

  initial begin
    for (int a = 0; a < TD; a++) store[a] = '0;
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < NL; k++) begin
      if (wr && wmask[k]) store[addr][k*GRAN +: GRAN] <= wdata[k*GRAN +: GRAN];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     raddr_q <= '0;
    else if (rd) raddr_q <= addr;
  end

  assign rdata = store[raddr_q];
endmodule

// File: rtl/tiled_mem.sv
module tiled_mem
  import tiled_mem_pkg::*;
#(
  parameter int       DATA_W     = 20,
  parameter int       DEPTH      = 64,
  parameter int       TILE_W     = 8,
  parameter int       TILE_DEPTH = 16,
  parameter int       GRAN       = 4,
  parameter pin_pol_e CE_POL     = PIN_HIGH,
  parameter pin_pol_e WE_POL     = PIN_HIGH,
  parameter pin_pol_e RE_POL     = PIN_HIGH,
  parameter int       CFG_W      = 4,
  parameter logic [CFG_W-1:0] CFG_TIE  = 4'hA,
  parameter logic [CFG_W-1:0] TILE_KEY = 4'hA,
  localparam int      ADDR_W     = $clog2(DEPTH),
  localparam int      LANES      = DATA_W / GRAN
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mem_en,
  input  logic              mem_we,
  input  logic              mem_re,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_wdata,
  input  logic [LANES-1:0]  mem_wmask,
  output logic [DATA_W-1:0] mem_rdata
);
  localparam int LO_W   = $clog2(TILE_DEPTH);
  localparam int NBANK  = DEPTH / TILE_DEPTH;
  localparam int NCOL   = cdiv(DATA_W, TILE_W);
  localparam int PAD_W  = NCOL * TILE_W;
  localparam int TLANES = TILE_W / GRAN;
  localparam int PAD_L  = NCOL * TLANES;
  localparam int BSEL_W = (NBANK > 1) ? $clog2(NBANK) : 1;

  logic [BSEL_W-1:0]      bsel, rbank_q;
  logic [LO_W-1:0]        lo_addr;
  logic [NBANK-1:0]       bank_ce, bank_we, bank_re;
  logic [NBANK-1:0]       ce_pin, we_pin, re_pin;
  logic [PAD_W-1:0]       wdata_pad, rd_pad;
  logic [PAD_L-1:0]       wmask_pad;
  logic [NBANK*PAD_W-1:0] rd_all;
  logic [CFG_W-1:0]       cfg_tie;

  assign lo_addr   = mem_addr[LO_W-1:0];
  assign wdata_pad = PAD_W'(mem_wdata);
  assign wmask_pad = PAD_L'(mem_wmask);
  assign cfg_tie   = CFG_TIE;

  generate
    if (NBANK > 1) begin : g_bsel
      assign bsel = mem_addr[ADDR_W-1:LO_W];
    end else begin : g_nobsel
      assign bsel = '0;
    end
  endgenerate

  tm_bank_dec #(.NBANK(NBANK), .BSEL_W(BSEL_W)) u_dec (
    .en(mem_en), .we(mem_we), .re(mem_re), .bsel(bsel),
    .bank_ce(bank_ce), .bank_we(bank_we), .bank_re(bank_re)
  );

  always_ff @(posedge clk) begin
    if (rst)                   rbank_q <= '0;
    else if (mem_en && mem_re) rbank_q <= bsel;
  end

  for (genvar i = 0; i < NBANK; i++) begin : g_row
    tm_pin_drv #(.POL(CE_POL)) u_ce (.act(bank_ce[i]), .pin(ce_pin[i]));
    tm_pin_drv #(.POL(WE_POL)) u_we (.act(bank_we[i]), .pin(we_pin[i]));
    tm_pin_drv #(.POL(RE_POL)) u_re (.act(bank_re[i]), .pin(re_pin[i]));
    for (genvar j = 0; j < NCOL; j++) begin : g_col
      tm_tile #(
        .TW(TILE_W), .TD(TILE_DEPTH), .GRAN(GRAN),
        .CE_POL(CE_POL), .WE_POL(WE_POL), .RE_POL(RE_POL),
        .CFG_W(CFG_W), .CFG_KEY(TILE_KEY)
      ) u_tile (
        .clk   (clk),
        .rst   (rst),
        .ce_pin(ce_pin[i]),
        .we_pin(we_pin[i]),
        .re_pin(re_pin[i]),
        .addr  (lo_addr),
        .wdata (wdata_pad[j*TILE_W +: TILE_W]),
        .wmask (wmask_pad[j*TLANES +: TLANES]),
        .cfg   (cfg_tie),
        .rdata (rd_all[(i*NCOL+j)*TILE_W +: TILE_W])
      );
    end
  end

  always_comb begin
    rd_pad = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (rbank_q == BSEL_W'(b)) rd_pad = rd_all[b*PAD_W +: PAD_W];
    end
  end

  assign mem_rdata = rd_pad[DATA_W-1:0];
endmodule

// File: rtl/tiled_mem_chk.sv
module tiled_mem_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 20,
  parameter int NBANK  = 4,
  parameter int BSEL_W = 2,
  parameter int LO_W   = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              re,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdata,
  input logic [NBANK-1:0]  bank_ce,
  input logic [BSEL_W-1:0] rbank_q
);
  AST_BANK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bank_ce)); // R4
  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    !en |-> (bank_ce == '0)); // R6
  AST_IDLE_RDATA_STABLE: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(rdata)); // R3
  AST_BANK_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (en && re) |=> (rbank_q == BSEL_W'($past(addr) >> LO_W))); // R2
  AST_BANK_HELD: assert property (@(posedge clk) disable iff (rst)
    !(en && re) |=> $stable(rbank_q)); // R3
endmodule

bind tiled_mem tiled_mem_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NBANK(NBANK), .BSEL_W(BSEL_W), .LO_W(LO_W)
) u_chk (
  .clk(clk), .rst(rst), .en(mem_en), .re(mem_re), .addr(mem_addr),
  .rdata(mem_rdata), .bank_ce(bank_ce), .rbank_q(rbank_q)
);

// File: tb/test_tiled_mem.sv
`timescale 1ns/1ps
module test_tiled_mem;
  import tiled_mem_pkg::*;
  localparam int DW = 20, DEP = 64, AW = 6, GR = 4, NL = DW / GR;

  logic clk = 1'b0, rst = 1'b1;
  logic en = 0, we = 0, re = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rd_a, rd_b;
  logic [NL-1:0] wmask = '0;
  logic [DW-1:0] refm [DEP];
  logic [DW-1:0] expq [$];
  string         tagq [$];
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tiled_mem i_tiled_mem (
    .clk(clk), .rst(rst), .mem_en(en), .mem_we(we), .mem_re(re), .mem_addr(addr),
    .mem_wdata(wdata), .mem_wmask(wmask), .mem_rdata(rd_a));

  tiled_mem #(.CE_POL(PIN_LOW), .WE_POL(PIN_LOW), .RE_POL(PIN_HIGH)) i_tiled_mem_lo (
    .clk(clk), .rst(rst), .mem_en(en), .mem_we(we), .mem_re(re), .mem_addr(addr),
    .mem_wdata(wdata), .mem_wmask(wmask), .mem_rdata(rd_b));

  task automatic chk(input string tag, input logic [DW-1:0] exp);
    total++;
    if (rd_a !== exp) begin
      bad++; $display("FAIL %s high-pin copy: got %h expected %h", tag, rd_a, exp);
    end
    total++;
    if (rd_b !== exp) begin
      bad++; $display("FAIL %s R8 low-pin copy: got %h expected %h", tag, rd_b, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    en = 0; we = 0; re = 0;
  endtask

  task automatic do_write(input int a, input logic [DW-1:0] d, input logic [NL-1:0] m,
                          input bit gate = 1);
    en = gate; we = 1; re = 0; addr = AW'(a); wdata = d; wmask = m;
    if (gate) begin
      for (int k = 0; k < NL; k++)
        if (m[k]) refm[a][k*GR +: GR] = d[k*GR +: GR];
    end
    step();
  endtask

  task automatic do_read(input int a, input string tag);
    en = 1; we = 0; re = 1; addr = AW'(a);
    @(posedge clk); #1;
    expq.push_back(refm[a]); tagq.push_back(tag);
    en = 0; re = 0;
  endtask

  // monitor: pops expected read words half a cycle after the read edge
  always @(negedge clk) begin
    if (expq.size() > 0) begin
      logic [DW-1:0] e;
      string t;
      e = expq.pop_front(); t = tagq.pop_front();
      chk(t, e);
    end
  end

  initial begin
    #(8 * 200000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] held;
    for (int a = 0; a < DEP; a++) refm[a] = '0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk("R7 reset read", '0);

    do_write(5, 20'hABCDE, '1);
    do_read(5, "R2 R9 full word read bank0");
    do_write(21, 20'h13579, '1);
    do_read(21, "R4 bank1 same low address");
    do_read(5, "R4 bank0 untouched by bank1 write");
    do_write(53, 20'hFFFFF, '1);
    do_read(37, "R4 bank2 untouched");
    do_read(53, "R4 bank3 written");
    do_write(5, 20'h00000, 5'b00100);
    do_read(5, "R1 single middle lane write");
    do_write(5, 20'h55555, 5'b10000);
    do_read(5, "R5 R1 partial last column lane");
    do_write(5, 20'h00F00, 5'b00001);
    do_read(5, "R1 lane0 only");
    do_write(21, 20'h22222, '1, 0);
    do_read(21, "R6 write strobe without enable");

    // hold: moving address with no read issued
    do_read(53, "R3 prime held location");
    @(negedge clk);
    held = refm[53];
    en = 1; re = 0; addr = 6'd5;
    @(posedge clk); #1;
    chk("R3 enable without read strobe", held);
    en = 0; re = 1; addr = 6'd21;
    @(posedge clk); #1;
    chk("R3 read strobe without enable", held);
    do_write(53, 20'h0F0F0, '1);
    chk("R3 held location shows new write", refm[53]);

    for (int n = 0; n < 600; n++) begin
      int a, op;
      a = $urandom_range(0, DEP - 1);
      op = $urandom_range(0, 9);
      if (op < 4) do_write(a, DW'($urandom), NL'($urandom), 1);
      else if (op < 8) do_read(a, "R1 R4 R5 random read");
      else if (op == 8) do_write(a, DW'($urandom), NL'($urandom), 0);
      else step();
    end
    for (int a = 0; a < DEP; a++) do_read(a, "R5 final sweep");
    repeat (2) @(posedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule